// File: doc/BRIEF.md
# Signal Quality Index Capture Unit

This block turns mean-square-error readings from the four cable pairs of a wired link into a 3-bit quality grade. Grade 7 is the cleanest signal and grade 0 is the noisiest. The grade for a reading is the number of programmable thresholds that the reading does not exceed. A larger error therefore gives a lower grade. Software programs seven ascending 16-bit thresholds through a small register port, which has a strobe, an address and data.

Software turns the mapping on with an enable bit in the configuration word. It takes a snapshot by writing the same word with a self-clearing capture bit and a 2-bit pair selector. The snapshot grade then appears in the result word. Beside it, the result word shows the lowest grade the selected pair has reached since that pair's result was last read. Each pair keeps its own lowest-grade tracker, and reading the result rearms the selected pair's tracker.

Top module: `sqi_capture_unit`

## Requirements
- R1: The grade of a reading equals the count of thresholds greater than or equal to it. It ranges from 0 (worst) to 7 (best), given seven 16-bit thresholds programmed in ascending order.
- R2: The register map is as follows:
  - Address 0 is the configuration word: enable in bit 0, capture in bit 1, pair selector in bits [5:4].
  - Address 1 is the result word: snapshot grade in bits [2:0], lowest grade in bits [6:4].
  - Addresses 2 to 8 hold thresholds 0 to 6. They can be read back.
- R3: While enable is clear, the result word reads zero, and incoming readings do not change any lowest-grade tracker.
- R4: A configuration write with capture and enable both set latches the grade of the most recent reading of the pair named in that write. The latched grade is visible from the next cycle.
- R5: The capture bit is never stored as a level, so it always reads back as 0. Enable and the pair selector read back as written.
- R6: The lowest-grade field gives the minimum grade among the selected pair's readings since that pair's last result read.
- R7: Each pair has its own tracker. A result read sets only the selected pair's tracker back to 7.
- R8: When a result read and a reading for the selected pair arrive in the same cycle, the read returns the old minimum. The tracker then restarts from that reading's grade, not from 7.
- R9: After reset, the following hold:
  - The configuration word is 0.
  - Every threshold is 0.
  - The snapshot grade is 0.
  - Every tracker holds 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mse_data | input | 64 | Four 16-bit error readings, pair 0 in the low bits |
| mse_vld | input | 4 | Per-pair strobe marking a new reading |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a result read rearms a tracker) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from address |

## Verification
The result read that rearms a tracker and a new reading for the same pair can both land in one cycle. The bench provokes this by raising the read strobe and that pair's valid strobe on the same clock. It checks two things. First, the read returns the minimum from before the collision. Second, the following read reports the colliding reading's grade, rather than 7 or the older minimum. Around this, a dense sweep of error values runs across all pairs. It straddles every threshold edge and compares each snapshot and minimum with a grade computed arithmetically in the bench.

// File: rtl/sqi_pkg.sv
package sqi_pkg;
    parameter int MSE_W    = 16;
    parameter int NUM_THR  = 7;
    parameter int NUM_PAIR = 4;
    parameter int IDX_W    = 3;
    parameter int DATA_W   = 16;
    parameter int ADDR_W   = 4;

    localparam int ADDR_CFG  = 0;
    localparam int ADDR_RES  = 1;
    localparam int ADDR_THR0 = 2;

    localparam int CFG_EN_BIT    = 0;
    localparam int CFG_CAP_BIT   = 1;
    localparam int CFG_PAIR_LSB  = 4;
    localparam int RES_WORST_LSB = 4;
endpackage

// File: rtl/sqi_index_map.sv
module sqi_index_map #(
    parameter int MSE_W   = 16,
    parameter int NUM_THR = 7,
    parameter int IDX_W   = 3
) (
    input  logic [MSE_W-1:0]              mse,
    input  logic [NUM_THR-1:0][MSE_W-1:0] thr,
    output logic [IDX_W-1:0]              idx
);
    logic [IDX_W-1:0] cnt_d;

    always_comb begin
        cnt_d = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            if (mse <= thr[i]) cnt_d = cnt_d + IDX_W'(1);
        end
    end

    assign idx = cnt_d;
endmodule

// File: rtl/sqi_worst_track.sv
module sqi_worst_track #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             smp_vld,
    input  logic [IDX_W-1:0] smp_idx,
    input  logic             clr,
    output logic [IDX_W-1:0] worst
);
    localparam logic [IDX_W-1:0] BEST = {IDX_W{1'b1}};

    logic [IDX_W-1:0] worst_d, worst_q, base_d;

    always_comb begin
        base_d  = clr ? BEST : worst_q;
        worst_d = base_d;
        if (en && smp_vld && (smp_idx < base_d)) worst_d = smp_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) worst_q <= BEST;
        else        worst_q <= worst_d;
    end

    assign worst = worst_q;

    // R7
    clr_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(en && smp_vld)) |=> (worst_q == BEST));

    // R6
    no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (worst_q <= $past(worst_q)));

    // R6
    sample_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && smp_vld) |=> (worst_q <= $past(smp_idx)));
endmodule

// File: rtl/sqi_capture_unit.sv
module sqi_capture_unit
    import sqi_pkg::*;
#(
    parameter int P_MSE_W    = MSE_W,
    parameter int P_NUM_THR  = NUM_THR,
    parameter int P_NUM_PAIR = NUM_PAIR,
    parameter int P_IDX_W    = IDX_W,
    parameter int P_DATA_W   = DATA_W,
    parameter int P_ADDR_W   = ADDR_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [P_NUM_PAIR*P_MSE_W-1:0]    mse_data,
    input  logic [P_NUM_PAIR-1:0]            mse_vld,
    input  logic                             reg_wr,
    input  logic                             reg_rd,
    input  logic [P_ADDR_W-1:0]              reg_addr,
    input  logic [P_DATA_W-1:0]              reg_wdata,
    output logic [P_DATA_W-1:0]              reg_rdata
);
    localparam int PAIR_W = $clog2(P_NUM_PAIR);

    typedef struct packed {
        logic                                en;
        logic [PAIR_W-1:0]                   pair;
        logic [P_IDX_W-1:0]                  cap_idx;
        logic [P_NUM_THR-1:0][P_MSE_W-1:0]   thr;
        logic [P_NUM_PAIR-1:0][P_MSE_W-1:0]  mse;
    } state_t;

    state_t st_d, st_q;

    logic [P_NUM_PAIR-1:0][P_IDX_W-1:0] smp_idx;
    logic [P_NUM_PAIR-1:0][P_IDX_W-1:0] hold_idx;
    logic [P_NUM_PAIR-1:0][P_IDX_W-1:0] worst;
    logic                               res_rd;
    logic                               cfg_wr;
    logic [PAIR_W-1:0]                  wr_pair;

    assign res_rd  = reg_rd && (reg_addr == P_ADDR_W'(ADDR_RES));
    assign cfg_wr  = reg_wr && (reg_addr == P_ADDR_W'(ADDR_CFG));
    assign wr_pair = reg_wdata[CFG_PAIR_LSB +: PAIR_W];

    for (genvar p = 0; p < P_NUM_PAIR; p++) begin : g_pair
        sqi_index_map #(.MSE_W(P_MSE_W), .NUM_THR(P_NUM_THR), .IDX_W(P_IDX_W)) u_live_map (
            .mse (mse_data[p*P_MSE_W +: P_MSE_W]),
            .thr (st_q.thr),
            .idx (smp_idx[p])
        );
        sqi_index_map #(.MSE_W(P_MSE_W), .NUM_THR(P_NUM_THR), .IDX_W(P_IDX_W)) u_hold_map (
            .mse (st_q.mse[p]),
            .thr (st_q.thr),
            .idx (hold_idx[p])
        );
        sqi_worst_track #(.IDX_W(P_IDX_W)) u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (st_q.en),
            .smp_vld (mse_vld[p]),
            .smp_idx (smp_idx[p]),
            .clr     (res_rd && (st_q.pair == PAIR_W'(p))),
            .worst   (worst[p])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < P_NUM_PAIR; p++) begin
            if (mse_vld[p]) st_d.mse[p] = mse_data[p*P_MSE_W +: P_MSE_W];
        end
        if (cfg_wr) begin
            st_d.en   = reg_wdata[CFG_EN_BIT];
            st_d.pair = wr_pair;
            if (reg_wdata[CFG_CAP_BIT] && reg_wdata[CFG_EN_BIT])
                st_d.cap_idx = hold_idx[wr_pair];
        end
        for (int i = 0; i < P_NUM_THR; i++) begin
            if (reg_wr && (reg_addr == P_ADDR_W'(ADDR_THR0 + i)))
                st_d.thr[i] = reg_wdata[P_MSE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == P_ADDR_W'(ADDR_CFG)) begin
            reg_rdata[CFG_EN_BIT]                = st_q.en;
            reg_rdata[CFG_PAIR_LSB +: PAIR_W]    = st_q.pair;
        end else if (reg_addr == P_ADDR_W'(ADDR_RES)) begin
            if (st_q.en) begin
                reg_rdata[P_IDX_W-1:0]               = st_q.cap_idx;
                reg_rdata[RES_WORST_LSB +: P_IDX_W]  = worst[st_q.pair];
            end
        end
        for (int i = 0; i < P_NUM_THR; i++) begin
            if (reg_addr == P_ADDR_W'(ADDR_THR0 + i))
                reg_rdata[P_MSE_W-1:0] = st_q.thr[i];
        end
    end

    // R3
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && reg_addr == P_ADDR_W'(ADDR_RES)) |-> (reg_rdata == '0));

    // R5
    cap_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && reg_wdata[CFG_CAP_BIT]) |=>
            (reg_addr != P_ADDR_W'(ADDR_CFG) || !reg_rdata[CFG_CAP_BIT]));

    // R4
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(st_q.cap_idx));
endmodule

// File: tb/sqi_capture_unit_tb.sv
module sqi_capture_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] mse_data = '0;
    logic [3:0]  mse_vld = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int n_chk = 0;
    int n_err = 0;
    int thr_m [7];

    always #2 clk = ~clk;

    sqi_capture_unit u_dut (
        .clk(clk), .rst_n(rst_n), .mse_data(mse_data), .mse_vld(mse_vld),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic int grade(int m);
        int c = 0;
        for (int i = 0; i < 7; i++) if (m <= thr_m[i]) c++;
        return c;
    endfunction

    function automatic logic [15:0] cfg(int pair, bit cap, bit en);
        return 16'((pair << 4) | (int'(cap) << 1) | int'(en));
    endfunction

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic do_wr(int a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(int a, output logic [15:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'(a);
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic push(int p, int m);
        @(negedge clk);
        mse_vld = '0; mse_vld[p] = 1'b1; mse_data[p*16 +: 16] = 16'(m);
        @(negedge clk);
        mse_vld = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #400000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 7; i++) thr_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        do_rd(0, v); check("R9 cfg after reset", v, 0);
        do_rd(1, v); check("R9 result after reset", v, 0);
        do_rd(2, v); check("R9 thr0 after reset", v, 0);
        do_rd(8, v); check("R9 thr6 after reset", v, 0);

        // R2 program thresholds and read back
        for (int i = 0; i < 7; i++) begin
            thr_m[i] = 100 * (i + 1);
            do_wr(2 + i, 16'(thr_m[i]));
        end
        for (int i = 0; i < 7; i++) begin
            do_rd(2 + i, v); check("R2 threshold readback", v, thr_m[i]);
        end

        // R9 trackers start at 7
        do_wr(0, cfg(0, 0, 1));
        do_rd(1, v);
        check("R9 snapshot zero", v[2:0], 0);
        check("R9 tracker seven", v[6:4], 7);

        // R5 capture bit reads zero, fields read back
        do_wr(0, cfg(2, 1, 1));
        do_rd(0, v); check("R5 cfg readback", v, 16'h0021);
        do_wr(0, cfg(3, 0, 1));
        do_rd(0, v); check("R5 cfg readback pair3", v, 16'h0031);

        // clear all trackers
        for (int p = 0; p < 4; p++) begin
            do_wr(0, cfg(p, 0, 1));
            do_rd(1, v);
        end

        // R1 R4 R6 sweep over error values across pairs
        for (int m = 0; m <= 720; m++) begin
            int p = m % 4;
            push(p, m);
            do_wr(0, cfg(p, 1, 1));
            do_rd(1, v);
            check("R1 R4 snapshot grade", v[2:0], grade(m));
            check("R6 lowest grade", v[6:4], grade(m));
        end
        push(1, 65535);
        do_wr(0, cfg(1, 1, 1));
        do_rd(1, v);
        check("R1 max error grade", v[2:0], 0);

        // R6 R7 minimum and independence
        do_wr(0, cfg(2, 0, 1)); do_rd(1, v);
        do_wr(0, cfg(3, 0, 1)); do_rd(1, v);
        push(2, 650);
        push(2, 150);
        push(3, 750);
        do_wr(0, cfg(2, 1, 1));
        do_rd(1, v);
        check("R4 latest grade pair2", v[2:0], grade(150));
        check("R6 minimum pair2", v[6:4], grade(650));
        do_rd(1, v);
        check("R7 rearm to seven", v[6:4], 7);
        do_wr(0, cfg(3, 0, 1));
        do_rd(1, v);
        check("R7 pair3 independent", v[6:4], grade(750));

        // R8 read and sample collide
        do_wr(0, cfg(1, 0, 1)); do_rd(1, v);
        push(1, 350);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'd1;
        mse_vld = 4'b0010; mse_data[16 +: 16] = 16'd250;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; mse_vld = '0;
        check("R8 old minimum returned", v[6:4], grade(350));
        do_rd(1, v);
        check("R8 tracker restarts at sample", v[6:4], grade(250));

        // R3 disabled
        do_wr(0, cfg(1, 1, 0));
        do_rd(1, v); check("R3 result zero when off", v, 0);
        push(1, 750);
        do_wr(0, cfg(1, 0, 1));
        do_rd(1, v);
        check("R3 tracker untouched when off", v[6:4], 7);

        summary();
        $finish;
    end
endmodule